// File: doc/BRIEF.md
# Parallel Despreading Correlator Bank

This block despreads a window of pulse-matched-filter outputs against a pseudo-noise chip stream. Each lane owns one sample position of the receive window, which is one timing hypothesis. On every cycle that carries a chip, every active lane multiplies its own sample by the shared chip, which is either +1 or -1, and adds the product to a running sum.

A symbol strobe marks the symbol boundary. When the strobe arrives, each lane copies its sum into an output register and starts the next sum. A one-cycle valid pulse announces the new set of results, so a peak search further down the receive path can pick the strongest hypothesis.

An enable bit for each lane lets a search controller keep only some positions active, for example a handful of acquisition phases out of the full window. A lane that is switched off keeps its sum at zero, which saves switching power.

Top module: `pn_corr_bank`

## Requirements
- R1: After synchronous reset, every lane result is zero and the valid output is low.
- R2: On a cycle with the chip enable high and no strobe, each enabled lane adds its sample when the chip input is 1 (chip +1) and subtracts it when the chip input is 0 (chip -1). A cycle with the chip enable low leaves the sum unchanged.
- R3: The sum is ACC_W = SAMP_W + clog2(MAX_CHIPS) + 1 bits wide, two's complement. A symbol of MAX_CHIPS chips at the most negative or most positive sample, with either chip sign, is reported exactly.
- R4: The valid output is high in the cycle after a strobe and low in the cycle after a cycle without a strobe.
- R5: On a strobe cycle, each enabled lane reports the sum of the chips before that cycle. A chip presented in the strobe cycle itself is the first chip of the next sum, so no chip is lost.
- R6: A strobe with the chip enable low starts the next sum from zero.
- R7: While a lane's enable bit is low, its result reads zero from the next cycle on and its sum is held at zero. After re-enabling, the lane accumulates from zero.
- R8: Between strobes, the result of an enabled lane holds its latched value while accumulation continues.
- R9: Lanes are independent: lane i uses only sample slot i (bits i*SAMP_W upward) and reports in result slot i (bits i*ACC_W upward).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| samples_i | input | LANES*SAMP_W | Signed matched-filter samples, lane i in slot i |
| chip_i | input | 1 | Current chip: 1 means +1, 0 means -1 |
| chip_en_i | input | 1 | Chip present this cycle |
| sym_strobe_i | input | 1 | Symbol boundary: latch and restart the sums |
| lane_en_i | input | LANES | Enable for each lane |
| corr_o | output | LANES*ACC_W | Latched signed correlation results |
| corr_valid_o | output | 1 | One-cycle pulse when new results are latched |

## Verification
The sums update at the edge that samples a chip. The results and the valid pulse appear after the edge that samples the strobe, one register deep. A disabled lane reads zero after the edge that samples its cleared enable bit.

The bench drives every input just after a falling edge and lets exactly one rising edge pass. It then compares the outputs at the next falling edge with a model that it updates by the requirement rules. Each result is therefore checked in the first cycle it is due, and valid is checked again one cycle later to confirm that it falls.

// File: rtl/pncb_pkg.sv
package pncb_pkg;

    localparam int LANES_DEF     = 32;
    localparam int SAMP_W_DEF    = 8;
    localparam int MAX_CHIPS_DEF = 1024;

    typedef enum logic {
        CHIP_NEG = 1'b0,
        CHIP_POS = 1'b1
    } chip_e;

    typedef struct packed {
        chip_e chip;
        logic  chip_en;
        logic  strobe;
    } chip_ctl_t;

    // sum of max_chips signed samples, incl. +2^(w-1)*max_chips
    function automatic int acc_width(input int samp_w, input int max_chips);
        return samp_w + $clog2(max_chips) + 1;
    endfunction

endpackage

// File: rtl/pn_corr_framer.sv
module pn_corr_framer
    import pncb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      chip_i,
    input  logic      chip_en_i,
    input  logic      sym_strobe_i,
    output chip_ctl_t ctl_o,
    output logic      valid_o
);
    always_comb begin
        ctl_o.chip    = chip_i ? CHIP_POS : CHIP_NEG;
        ctl_o.chip_en = chip_en_i;
        ctl_o.strobe  = sym_strobe_i;
    end

    always_ff @(posedge clk) begin
        if (rst) valid_o <= 1'b0;
        else     valid_o <= sym_strobe_i;
    end
endmodule

// File: rtl/pn_corr_lane.sv
module pn_corr_lane
    import pncb_pkg::*;
#(
    parameter int SAMP_W = SAMP_W_DEF,
    parameter int ACC_W  = acc_width(SAMP_W_DEF, MAX_CHIPS_DEF)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     lane_en,
    input  chip_ctl_t                ctl,
    input  logic signed [SAMP_W-1:0] sample,
    output logic signed [ACC_W-1:0]  corr
);
    logic signed [ACC_W-1:0] ext;
    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] acc_q;

    always_comb begin
        ext  = ACC_W'(sample);
        prod = (ctl.chip == CHIP_POS) ? ext : -ext;
    end

    always_ff @(posedge clk) begin
        if (rst || !lane_en) begin
            acc_q <= '0;
        end else if (ctl.strobe) begin
            acc_q <= ctl.chip_en ? prod : '0;
        end else if (ctl.chip_en) begin
            acc_q <= acc_q + prod;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !lane_en) corr <= '0;
        else if (ctl.strobe) corr <= acc_q;
    end
endmodule

// File: rtl/pn_corr_bank.sv
module pn_corr_bank
    import pncb_pkg::*;
#(
    parameter int LANES     = LANES_DEF,
    parameter int SAMP_W    = SAMP_W_DEF,
    parameter int MAX_CHIPS = MAX_CHIPS_DEF,
    parameter int ACC_W     = acc_width(SAMP_W, MAX_CHIPS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES*SAMP_W-1:0] samples_i,
    input  logic                    chip_i,
    input  logic                    chip_en_i,
    input  logic                    sym_strobe_i,
    input  logic [LANES-1:0]        lane_en_i,
    output logic [LANES*ACC_W-1:0]  corr_o,
    output logic                    corr_valid_o
);
    chip_ctl_t ctl;

    pn_corr_framer u_framer (
        .clk          (clk),
        .rst          (rst),
        .chip_i       (chip_i),
        .chip_en_i    (chip_en_i),
        .sym_strobe_i (sym_strobe_i),
        .ctl_o        (ctl),
        .valid_o      (corr_valid_o)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [ACC_W-1:0] lane_corr;

        pn_corr_lane #(
            .SAMP_W (SAMP_W),
            .ACC_W  (ACC_W)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .lane_en (lane_en_i[g]),
            .ctl     (ctl),
            .sample  (samples_i[g*SAMP_W +: SAMP_W]),
            .corr    (lane_corr)
        );

        assign corr_o[g*ACC_W +: ACC_W] = lane_corr;
    end
endmodule

// File: rtl/pn_corr_bank_chk.sv
module pn_corr_bank_chk #(
    parameter int LANES     = 32,
    parameter int SAMP_W    = 8,
    parameter int MAX_CHIPS = 1024,
    parameter int ACC_W     = 19
) (
    input logic                    clk,
    input logic                    rst,
    input logic [LANES*SAMP_W-1:0] samples_i,
    input logic                    chip_i,
    input logic                    chip_en_i,
    input logic                    sym_strobe_i,
    input logic [LANES-1:0]        lane_en_i,
    input logic [LANES*ACC_W-1:0]  corr_o,
    input logic                    corr_valid_o
);
    p_valid_after_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        sym_strobe_i |=> corr_valid_o);

    p_no_valid_without_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !sym_strobe_i |=> !corr_valid_o);

    for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
        p_disabled_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
            !lane_en_i[g] |=> (corr_o[g*ACC_W +: ACC_W] == '0));

        p_result_holds_r8: assert property (@(posedge clk) disable iff (rst)
            (!sym_strobe_i && lane_en_i[g]) |=> $stable(corr_o[g*ACC_W +: ACC_W]));
    end
endmodule

bind pn_corr_bank pn_corr_bank_chk #(
    .LANES     (LANES),
    .SAMP_W    (SAMP_W),
    .MAX_CHIPS (MAX_CHIPS),
    .ACC_W     (ACC_W)
) u_chk (.*);

// File: tb/pn_corr_bank_test.sv
module pn_corr_bank_test;
    localparam int LN = 4;
    localparam int SW = 8;
    localparam int MC = 1024;
    localparam int AW = SW + $clog2(MC) + 1;

    logic              clk = 1'b0;
    logic              rst;
    logic [LN*SW-1:0]  samples_i;
    logic              chip_i, chip_en_i, sym_strobe_i;
    logic [LN-1:0]     lane_en_i;
    logic [LN*AW-1:0]  corr_o;
    logic              corr_valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    int acc_m [LN];
    int out_m [LN];
    int smp   [LN];

    always #5 clk = ~clk;

    pn_corr_bank #(.LANES(LN), .SAMP_W(SW), .MAX_CHIPS(MC)) uut (.*);

    function automatic int lane_val(input int i);
        logic signed [AW-1:0] v;
        v = corr_o[i*AW +: AW];
        return int'(v);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_lanes(input string req);
        for (int i = 0; i < LN; i++) check(req, lane_val(i), out_m[i]);
    endtask

    task automatic set_samples(input int s0, input int s1, input int s2, input int s3);
        smp[0] = s0; smp[1] = s1; smp[2] = s2; smp[3] = s3;
        for (int i = 0; i < LN; i++) samples_i[i*SW +: SW] = SW'(smp[i]);
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input bit chip, input bit ce, input bit stb);
        chip_i = chip; chip_en_i = ce; sym_strobe_i = stb;
        @(posedge clk);
        for (int i = 0; i < LN; i++) begin
            int p;
            p = chip ? smp[i] : -smp[i];
            if (!lane_en_i[i]) begin
                acc_m[i] = 0; out_m[i] = 0;
            end else if (stb) begin
                out_m[i] = acc_m[i];
                acc_m[i] = ce ? p : 0;
            end else if (ce) begin
                acc_m[i] = acc_m[i] + p;
            end
        end
        @(negedge clk);
        chip_en_i = 1'b0; sym_strobe_i = 1'b0;
    endtask

    task automatic strobe_and_check(input bit ce, input string req);
        step(1'b1, ce, 1'b1);
        check(req, int'(corr_valid_o), 1);
        check_lanes(req);
    endtask

    task automatic t_reset;
        check("R1", int'(corr_valid_o), 0);
        for (int i = 0; i < LN; i++) check("R1", lane_val(i), 0);
    endtask

    task automatic t_basic;
        set_samples(10, -20, 30, -5);
        step(1, 1, 0); step(0, 1, 0); step(1, 0, 0);   // chip-enable low ignored
        step(1, 1, 0); step(1, 1, 0); step(0, 1, 0);
        step(0, 0, 0);
        strobe_and_check(1'b0, "R2/R9");
        check("R2", lane_val(0), 10);
        check("R9", lane_val(1), -20);
        step(0, 0, 0);
        check("R4", int'(corr_valid_o), 0);
    endtask

    task automatic t_strobe_chip;
        set_samples(7, 3, -9, 100);
        step(1, 1, 0); step(1, 1, 0);
        strobe_and_check(1'b1, "R5");
        check("R5", lane_val(3), 200);
        step(0, 1, 0);
        strobe_and_check(1'b0, "R5");
        check("R5", lane_val(0), 0);
        step(1, 1, 0);
        strobe_and_check(1'b0, "R6");
        check("R6", lane_val(2), -9);
    endtask

    task automatic t_hold;
        set_samples(1, 2, 3, 4);
        step(1, 1, 0);
        strobe_and_check(1'b0, "R8");
        for (int k = 0; k < 5; k++) step(0, 1, 0);
        check_lanes("R8");
        check("R8", lane_val(3), 4);
        strobe_and_check(1'b0, "R8");
        check("R8", lane_val(1), -10);
    endtask

    task automatic t_disable;
        set_samples(5, 6, 7, 8);
        step(1, 1, 0); step(1, 1, 0);
        strobe_and_check(1'b0, "R7");
        lane_en_i[2] = 1'b0;
        step(1, 1, 0);
        check("R7", lane_val(2), 0);
        step(1, 1, 0);
        strobe_and_check(1'b0, "R7");
        lane_en_i[2] = 1'b1;
        step(1, 1, 0); step(0, 1, 0); step(1, 1, 0);
        strobe_and_check(1'b0, "R7");
        check("R7", lane_val(2), 7);
    endtask

    task automatic t_overflow;
        set_samples(-128, 127, -128, 127);
        step(1, 1, 1);   // restart sums: the first chip sits in the strobe cycle
        for (int k = 1; k < MC; k++) step(0, 1, 0);
        step(0, 0, 0);
        strobe_and_check(1'b0, "R3");
        // chip +1 on the strobe cycle, then chip -1 for the rest
        check("R3", lane_val(0), -128 + 128 * (MC - 1));
        for (int k = 0; k < MC; k++) step(0, 1, 0);
        strobe_and_check(1'b0, "R3");
        check("R3", lane_val(0), 131072);
        check("R3", lane_val(1), -130048);
        for (int k = 0; k < MC; k++) step(1, 1, 0);
        strobe_and_check(1'b0, "R3");
        check("R3", lane_val(2), -131072);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; chip_i = 1'b0; chip_en_i = 1'b0; sym_strobe_i = 1'b0;
        lane_en_i = '1; samples_i = '0;
        for (int i = 0; i < LN; i++) begin acc_m[i] = 0; out_m[i] = 0; smp[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_strobe_chip();
        t_hold();
        t_disable();
        t_overflow();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule